// File: doc/BRIEF.md
# Threshold Calibration Sequencer

This block finds a comparator trip threshold by stepping a 12-bit DAC code upward from zero. At each step it waits a programmable settling time and then reads a synchronized copy of the comparator. It makes two sweeps. The first sweep runs with the bright light condition applied, and its trip code is kept as the high value. The block then asks external logic to switch to the dark condition and waits for an acknowledge. The second sweep runs the same way, and its trip code is kept as the dark value. Finally the block writes the midpoint of the two codes to the DAC and pulses done.

DAC writes leave the block on a valid/ready stream. A code is offered with `dac_valid_o` and is taken on any clock edge where `dac_ready_i` is also high. While ready stays low, the code and valid are held unchanged. The block makes no assumption about how long the DAC side stalls. Settling time is counted only from the edge on which a write is accepted. All other pins are plain levels or single-cycle pulses. If a sweep reaches the top code without a trip, the block stops with an error and writes no midpoint.

Top module: `thrcal_seq`

## Requirements
- R1: After reset, `dac_valid_o`, `dac_code_o`, `dark_req_o`, `high_code_o`, `dark_code_o`, `busy_o`, `done_o` and `err_o` are all zero.
- R2: A `start_i` pulse seen while idle begins a run. Each sweep writes codes 0, 1, 2 and so on, one accepted write per code, up to and including its trip code. A complete run therefore makes high+1 plus dark+1 plus 1 accepted writes.
- R3: While `dac_valid_o` is high and `dac_ready_i` is low, `dac_valid_o` stays high and `dac_code_o` stays stable on the next cycle.
- R4: After each accepted write, the comparator is read only once `settle_cycles_i` cycles plus the synchronizer depth have passed. The trip code is the first code whose own comparator response is high, even when `settle_cycles_i` is 0.
- R5: The trip code of the first sweep appears on `high_code_o`.
- R6: After the first sweep, `dark_req_o` rises and no DAC write is offered until `dark_ack_i` is seen high. `dark_req_o` then falls and the second sweep starts at code 0.
- R7: The trip code of the second sweep appears on `dark_code_o`.
- R8: The last write of a successful run is (high + dark) >> 1, computed over a 13-bit sum. After that write is accepted, `done_o` is high for exactly one cycle.
- R9: A sweep that reaches code 4095 without a trip raises `err_o` and ends the run with no midpoint write and no done pulse. `err_o` stays high until the next accepted start.
- R10: A `start_i` pulse while `busy_o` is high has no effect.
- R11: `busy_o` is high from the cycle after an accepted start until the run ends with done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that launches a calibration run |
| settle_cycles_i | input | SETTLE_W (8) | Extra wait cycles after each accepted write |
| cmp_async_i | input | 1 | Comparator output, asynchronous to clk |
| dark_ack_i | input | 1 | Dark condition is in place |
| dac_ready_i | input | 1 | DAC side accepts the offered code |
| dac_valid_o | output | 1 | A DAC code is offered |
| dac_code_o | output | CODE_W (12) | Offered DAC code |
| dark_req_o | output | 1 | Request to apply the dark condition |
| high_code_o | output | CODE_W (12) | Stored bright-pass trip code |
| dark_code_o | output | CODE_W (12) | Stored dark-pass trip code |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at successful completion |
| err_o | output | 1 | Sweep ended without a trip |

## Verification
Most internal faults show up in the stored codes and in the number of accepted writes. A step counter that is off by one, or a sweep that restarts, changes the write count or the stored code as soon as that sweep ends. A settle window that is too short makes the block trip one or more codes late, which is visible on `high_code_o` as soon as the first sweep finishes. A wrong midpoint or a lost overflow bit appears on the final accepted write, one cycle before `done_o`. A stuck sequencing state shows as `dark_req_o` or `done_o` never arriving. The tests include sweeps that end at code 0 and code 4095, sweeps under stalled ready, and sweeps that never trip.

// File: rtl/thrcal_pkg.sv
package thrcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_DARKREQ,
    ST_FINAL,
    ST_DONE
  } cal_state_t;
endpackage

// File: rtl/thrcal_sync.sv
module thrcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/thrcal_settle.sv
module thrcal_settle #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= count_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  AST_SETTLE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && count_i != '0) |=> !expired_o);  // R4
endmodule

// File: rtl/thrcal_seq.sv
module thrcal_seq
  import thrcal_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_async_i,
  input  logic                dark_ack_i,
  input  logic                dac_ready_i,
  output logic                dac_valid_o,
  output logic [CODE_W-1:0]   dac_code_o,
  output logic                dark_req_o,
  output logic [CODE_W-1:0]   high_code_o,
  output logic [CODE_W-1:0]   dark_code_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int CNT_W = SETTLE_W + 1;
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  cal_state_t        state_q;
  logic [CODE_W-1:0] code_q, high_q, dark_q;
  logic              pass_q, err_q;
  logic              cmp_s, expired, accept;
  logic [CODE_W:0]   pair_sum;
  logic [CNT_W-1:0]  settle_load;

  thrcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_async_i), .sync_o(cmp_s)
  );

  assign settle_load = {1'b0, settle_cycles_i} + CNT_W'(SYNC_STAGES);

  thrcal_settle #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(accept && state_q == ST_WRITE),
    .count_i(settle_load), .expired_o(expired)
  );

  assign dac_valid_o = (state_q == ST_WRITE) || (state_q == ST_FINAL);
  assign accept      = dac_valid_o && dac_ready_i;
  assign pair_sum    = {1'b0, high_q} + {1'b0, code_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      high_q  <= '0;
      dark_q  <= '0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          code_q  <= '0;
          high_q  <= '0;
          dark_q  <= '0;
          pass_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (accept) state_q <= ST_SETTLE;
        ST_SETTLE: if (expired) begin
          if (cmp_s) begin
            if (!pass_q) begin
              high_q  <= code_q;
              state_q <= ST_DARKREQ;
            end else begin
              dark_q  <= code_q;
              code_q  <= pair_sum[CODE_W:1];
              state_q <= ST_FINAL;
            end
          end else if (code_q == CODE_TOP) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            code_q  <= code_q + 1'b1;
            state_q <= ST_WRITE;
          end
        end
        ST_DARKREQ: if (dark_ack_i) begin
          pass_q  <= 1'b1;
          code_q  <= '0;
          state_q <= ST_WRITE;
        end
        ST_FINAL: if (accept) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_code_o  = code_q;
  assign dark_req_o  = (state_q == ST_DARKREQ);
  assign high_code_o = high_q;
  assign dark_code_o = dark_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid_o && !dac_ready_i) |=> (dac_valid_o && $stable(dac_code_o)));  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R8
  AST_NO_WRITE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dark_req_o |-> !dac_valid_o);  // R6
  AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o);  // R9
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dark_req_o |-> busy_o);  // R11
endmodule

// File: tb/thrcal_seq_bench.sv
module thrcal_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  settle_cycles_i = '0;
  logic        cmp_async_i;
  logic        dark_ack_i = 1'b0;
  logic        dac_ready_i = 1'b1;
  logic        dac_valid_o;
  logic [11:0] dac_code_o;
  logic        dark_req_o;
  logic [11:0] high_code_o, dark_code_o;
  logic        busy_o, done_o, err_o;

  int errors = 0;
  int checks = 0;

  logic [11:0] applied = '0;
  logic [12:0] thr_b = '0, thr_d = '0;
  logic        phase_dark = 1'b0;
  logic        stall_mode = 1'b0;
  int          wr_cnt = 0;
  int          done_cnt = 0;
  logic [11:0] last_wr = '0;

  always #5 clk = ~clk;

  thrcal_seq u_thrcal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
    .cmp_async_i(cmp_async_i), .dark_ack_i(dark_ack_i), .dac_ready_i(dac_ready_i),
    .dac_valid_o(dac_valid_o), .dac_code_o(dac_code_o), .dark_req_o(dark_req_o),
    .high_code_o(high_code_o), .dark_code_o(dark_code_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  assign cmp_async_i = ({1'b0, applied} >= (phase_dark ? thr_d : thr_b));

  always @(posedge clk) begin
    if (dac_valid_o && dac_ready_i) begin
      applied <= dac_code_o;
      last_wr <= dac_code_o;
      wr_cnt  <= wr_cnt + 1;
    end
    if (done_o) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) dac_ready_i <= stall_mode ? ~dac_ready_i : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_for(input bit want_req);
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (want_req ? (dark_req_o || err_o) : (done_o || err_o)) break;
    end
  endtask

  task automatic run_cal(input logic [12:0] b, input logic [12:0] d,
                         input logic [7:0] s, input bit stl, input bit poke);
    int w0, dn0, exp_mid;
    thr_b = b; thr_d = d; phase_dark = 1'b0;
    settle_cycles_i = s; stall_mode = stl;
    @(negedge clk);
    w0 = wr_cnt; dn0 = done_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
    chk(err_o == 1'b0, "R9 err cleared by start", err_o, 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    wait_for(1'b1);
    if (b > 13'd4095) begin
      chk(err_o == 1'b1, "R9 bright sweep no trip", err_o, 1);
      chk(wr_cnt - w0 == 4096, "R9 write count", wr_cnt - w0, 4096);
      chk(done_cnt == dn0, "R9 no done", done_cnt - dn0, 0);
      chk(busy_o == 1'b0, "R11 idle after err", busy_o, 0);
      return;
    end
    chk(dark_req_o == 1'b1, "R6 dark request", dark_req_o, 1);
    chk(high_code_o == b[11:0], "R5 high code", high_code_o, b);
    chk(wr_cnt - w0 == b + 1, "R2 first sweep writes", wr_cnt - w0, b + 1);
    if (poke) begin
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      chk(dark_req_o == 1'b1, "R10 start ignored in request", dark_req_o, 1);
    end
    repeat (5) @(negedge clk);
    chk(wr_cnt - w0 == b + 1, "R6 no write while waiting", wr_cnt - w0, b + 1);
    phase_dark = 1'b1;
    @(negedge clk);
    dark_ack_i = 1'b1; @(negedge clk); dark_ack_i = 1'b0;
    chk(dark_req_o == 1'b0, "R6 request drops after ack", dark_req_o, 0);
    wait_for(1'b0);
    if (d > 13'd4095) begin
      chk(err_o == 1'b1, "R9 dark sweep no trip", err_o, 1);
      chk(wr_cnt - w0 == b + 1 + 4096, "R9 no midpoint write", wr_cnt - w0, b + 4097);
      chk(done_cnt == dn0, "R9 no done", done_cnt - dn0, 0);
      return;
    end
    exp_mid = (int'(b) + int'(d)) >> 1;
    chk(done_o == 1'b1, "R8 done pulse", done_o, 1);
    chk(dark_code_o == d[11:0], "R7 dark code", dark_code_o, d);
    chk(int'(last_wr) == exp_mid, "R8 midpoint", last_wr, exp_mid);
    chk(wr_cnt - w0 == b + d + 3, "R2 total writes", wr_cnt - w0, b + d + 3);
    chk(err_o == 1'b0, "R9 no err on success", err_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8 R11 done single, idle", done_o, 0);
  endtask

  // {bright threshold, dark threshold, settle cycles, stall ready}
  localparam logic [34:0] VEC [5] = '{
    {13'd100,  13'd20,   8'd1, 1'b0},
    {13'd0,    13'd0,    8'd0, 1'b0},
    {13'd4095, 13'd4095, 8'd0, 1'b0},
    {13'd7,    13'd1000, 8'd2, 1'b1},
    {13'd301,  13'd300,  8'd5, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dac_valid_o && dac_code_o == 0 && !dark_req_o && high_code_o == 0 &&
        dark_code_o == 0 && !busy_o && !done_o && !err_o,
        "R1 reset state", {dac_valid_o, busy_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !dac_valid_o, "R1 idle after reset", busy_o, 0);
    for (int v = 0; v < 5; v++)
      run_cal(VEC[v][34:22], VEC[v][21:9], VEC[v][8:1], VEC[v][0], 1'b0);
    // R10: start pulses during a sweep and during the dark request
    run_cal(13'd40, 13'd60, 8'd1, 1'b0, 1'b1);
    // R9: bright sweep never trips
    run_cal(13'd4096, 13'd5, 8'd0, 1'b0, 1'b0);
    // R9: dark sweep never trips, then recovery with a fresh run
    run_cal(13'd3, 13'd4096, 8'd0, 1'b0, 1'b0);
    run_cal(13'd12, 13'd13, 8'd3, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule